// File: doc/BRIEF.md
# Memory Access Controller with Posted Writes

This block stands between a requesting control unit and a slow word-wide memory. It accepts one memory request at a time through a valid/ready handshake. It holds the target address in its own address register and the word in flight in its own buffer register. While an operation is in progress it drives a read strobe or a write strobe towards memory, and it waits for the memory's completion feedback rather than counting a fixed number of cycles. Reads and writes can therefore take different and varying times.

A read blocks the requestor. The word is returned on a one-cycle valid pulse, taken from the buffer register after the memory has signalled completion. A write is posted. The handshake completes in the cycle the request is accepted, so the requestor can carry on with internal work while the memory is still busy. No further memory request is taken until that write has finished and the strobes have rested for a programmable number of idle cycles. Only one word is transferred per operation, and only one operation is ever outstanding.

Top module: `mem_access_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_rd`, `mem_wr` and `rd_valid` are 0.
- R2: A read is accepted on a clock edge where `req_valid`=1, `req_ready`=1 and `req_we`=0. In the next cycle `mem_rd` is 1 and `mem_addr` equals the accepted address. `mem_rd` then stays 1 until a cycle in which `mem_done` is 1.
- R3: After a read's completion cycle (`mem_rd`=1 and `mem_done`=1), `rd_valid` is 1 for exactly one cycle. During that cycle `rd_data` equals the `mem_rdata` present in the completion cycle. `rd_valid` is never 1 except after a read completion.
- R4: A write is accepted on a clock edge where `req_valid`=1, `req_ready`=1 and `req_we`=1. In the next cycle `mem_wr` is 1, `mem_addr` equals the accepted address and `mem_wdata` equals the accepted data. `mem_wr` then stays 1 until a cycle in which `mem_done` is 1, and a write never produces `rd_valid`.
- R5: A write is posted. The handshake completes in the accepting cycle while the memory write is still in progress, so `req_ready` is 0 in the following cycle while `mem_wr` is 1.
- R6: `req_ready` is 0 whenever a strobe is asserted and during the recovery gap. A request presented while `req_ready` is 0 is ignored: it starts no strobe and does not change `mem_addr`.
- R7: `mem_rd` and `mem_wr` are never 1 together. After a completion cycle both strobes are 0 for at least `GAP_CYCLES` cycles before either is asserted again.
- R8: While a strobe is held waiting for completion, `mem_addr` and `mem_wdata` stay stable, even if the request inputs change.
- R9: Completion time comes only from `mem_done`, whatever the latency. A read issued right after a posted write to the same address returns the written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Requestor presents an operation |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Word to write |
| req_ready | output | 1 | Controller can accept a request this cycle |
| rd_valid | output | 1 | One-cycle pulse: read word available |
| rd_data | output | DATA_W | Read word, valid with rd_valid |
| mem_addr | output | ADDR_W | Address register contents towards memory |
| mem_wdata | output | DATA_W | Buffer register contents towards memory |
| mem_rd | output | 1 | Read strobe, held until completion |
| mem_wr | output | 1 | Write strobe, held until completion |
| mem_done | input | 1 | Completion feedback from memory |
| mem_rdata | input | DATA_W | Word returned by memory at read completion |

## Verification
The hardest situation to reach is a requestor that changes its mind while a posted write is still running. It moves the request lines, or presents a new read, while the write strobe waits on a slow completion. The bench reaches this by returning from every write task as soon as the handshake completes, then scrambling the request inputs and immediately presenting the next request while a memory model with pseudo-random latency of 1 to 5 cycles holds the write open. The sweep writes and reads back a block of addresses and then interleaves writes with reads to the same address, so that read-after-write ordering and the idle gap between strobes are exercised at every latency.

// File: rtl/mac_pkg.sv
package mac_pkg;

   typedef enum logic [1:0] {
      MAC_IDLE = 2'd0,
      MAC_RD   = 2'd1,
      MAC_WR   = 2'd2,
      MAC_GAP  = 2'd3
   } mac_state_e;

endpackage

// File: rtl/mac_reg.sv
module mac_reg #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_width
         $error("mac_reg: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (load)  q <= d;
   end

endmodule

// File: rtl/mac_seq.sv
module mac_seq
   import mac_pkg::*;
#(
   parameter int GAP_CYCLES = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_valid,
   input  logic req_we,
   input  logic mem_done,
   output logic accept,
   output logic rd_capture,
   output logic req_ready,
   output logic mem_rd,
   output logic mem_wr,
   output logic rd_valid
);

   localparam int GW = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES + 1) : 1;

   generate
      if (GAP_CYCLES < 1) begin : g_bad_gap
         $error("mac_seq: GAP_CYCLES must be at least 1");
      end
   endgenerate

   mac_state_e state_q, state_d;
   logic       gap_last;
   logic       rd_valid_q;

   assign req_ready  = (state_q == MAC_IDLE);
   assign accept     = req_valid && req_ready;
   assign mem_rd     = (state_q == MAC_RD);
   assign mem_wr     = (state_q == MAC_WR);
   assign rd_capture = mem_rd && mem_done;
   assign rd_valid   = rd_valid_q;

   generate
      if (GAP_CYCLES == 1) begin : g_gap_single
         assign gap_last = 1'b1;
      end else begin : g_gap_count
         logic [GW-1:0] gap_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   gap_cnt <= '0;
            else if (state_q != MAC_GAP)  gap_cnt <= '0;
            else                          gap_cnt <= gap_cnt + 1'b1;
         end
         assign gap_last = (gap_cnt == GW'(GAP_CYCLES - 1));
      end
   endgenerate

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         MAC_IDLE: if (accept)   state_d = req_we ? MAC_WR : MAC_RD;
         MAC_RD:   if (mem_done) state_d = MAC_GAP;
         MAC_WR:   if (mem_done) state_d = MAC_GAP;
         MAC_GAP:  if (gap_last) state_d = MAC_IDLE;
         default:                state_d = MAC_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q    <= MAC_IDLE;
         rd_valid_q <= 1'b0;
      end else begin
         state_q    <= state_d;
         rd_valid_q <= rd_capture;
      end
   end

   // R7: strobes exclusive
   assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   // R7: both strobes drop after completion
   assert_drop_after_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && mem_done) |=> (!mem_rd && !mem_wr));

   // R2: read strobe held until feedback
   assert_rd_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && !mem_done) |=> mem_rd);

   // R4: write strobe held until feedback
   assert_wr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_wr && !mem_done) |=> mem_wr);

   // R3: read pulse only after a read completion
   assert_rd_valid_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(mem_rd && mem_done));

   // R6: no acceptance while a strobe is up
   assert_busy_not_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd || mem_wr) |-> !req_ready);

endmodule

// File: rtl/mem_access_ctrl.sv
module mem_access_ctrl
   import mac_pkg::*;
#(
   parameter int ADDR_W     = 8,
   parameter int DATA_W     = 16,
   parameter int GAP_CYCLES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_we,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              req_ready,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              mem_rd,
   output logic              mem_wr,
   input  logic              mem_done,
   input  logic [DATA_W-1:0] mem_rdata
);

   generate
      if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
         $error("mem_access_ctrl: ADDR_W out of range 1..32");
      end
      if (DATA_W < 1) begin : g_bad_data
         $error("mem_access_ctrl: DATA_W must be at least 1");
      end
   endgenerate

   logic              accept;
   logic              rd_capture;
   logic              buf_load;
   logic [DATA_W-1:0] buf_d;
   logic [DATA_W-1:0] buf_q;
   logic [ADDR_W-1:0] adr_q;

   mac_seq #(
      .GAP_CYCLES (GAP_CYCLES)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_we     (req_we),
      .mem_done   (mem_done),
      .accept     (accept),
      .rd_capture (rd_capture),
      .req_ready  (req_ready),
      .mem_rd     (mem_rd),
      .mem_wr     (mem_wr),
      .rd_valid   (rd_valid)
   );

   mac_reg #(.W(ADDR_W)) u_adr_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .d     (req_addr),
      .q     (adr_q)
   );

   assign buf_load = rd_capture || (accept && req_we);
   assign buf_d    = rd_capture ? mem_rdata : req_wdata;

   mac_reg #(.W(DATA_W)) u_buf_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (buf_load),
      .d     (buf_d),
      .q     (buf_q)
   );

   assign mem_addr  = adr_q;
   assign mem_wdata = buf_q;
   assign rd_data   = buf_q;

   // R2: accepted read appears on the strobe with its address
   assert_rd_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && !req_we) |=> (mem_rd && mem_addr == $past(req_addr)));

   // R4: accepted write appears with address and data
   assert_wr_issue_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready && req_we) |=>
         (mem_wr && mem_addr == $past(req_addr) && mem_wdata == $past(req_wdata)));

   // R8: address and data stable while waiting
   assert_stable_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ((mem_rd || mem_wr) && !mem_done) |=> ($stable(mem_addr) && $stable(mem_wdata)));

   // R3: delivered word equals memory word at completion
   assert_rd_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_rd && mem_done) |=> (rd_valid && rd_data == $past(mem_rdata)));

endmodule

// File: tb/mem_access_ctrl_tb.sv
module mem_access_ctrl_tb;

   localparam int AW  = 8;
   localparam int DW  = 16;
   localparam int GAP = 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_we = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ready, rd_valid, mem_rd, mem_wr;
   logic [DW-1:0] rd_data, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic          mem_done;
   logic [DW-1:0] mem_rdata;

   always #2 clk = ~clk;

   mem_access_ctrl #(.ADDR_W(AW), .DATA_W(DW), .GAP_CYCLES(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_we(req_we),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
      .rd_valid(rd_valid), .rd_data(rd_data), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rd(mem_rd), .mem_wr(mem_wr),
      .mem_done(mem_done), .mem_rdata(mem_rdata)
   );

   int errors = 0;
   int checks = 0;
   int cyc    = 0;

   logic [DW-1:0] store [0:(1<<AW)-1];
   logic [DW-1:0] refm  [0:(1<<AW)-1];

   // slow memory model with pseudo-random latency 1..5
   logic [7:0] lfsr = 8'hA5;
   logic [2:0] lat  = 3'd3;
   logic [2:0] cnt  = 3'd0;
   initial mem_done  = 1'b0;
   initial mem_rdata = '0;

   always @(posedge clk) begin
      lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      mem_done <= 1'b0;
      if ((mem_rd || mem_wr) && !mem_done) begin
         if (cnt == lat - 3'd1) begin
            mem_done <= 1'b1;
            cnt      <= 3'd0;
            lat      <= 3'(lfsr % 5) + 3'd1;
            if (mem_wr) store[mem_addr] <= mem_wdata;
            else        mem_rdata <= store[mem_addr];
         end else begin
            cnt <= cnt + 3'd1;
         end
      end
   end

   task automatic chk(input bit ok, input string tag,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // port monitor: exclusion, hold, stability, recovery gap
   bit            prev_strobe = 0;
   bit            prev_done   = 0;
   logic [AW-1:0] prev_addr;
   logic [DW-1:0] prev_wdata;
   int            idle_run = 0;
   bit            seen_op  = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_rd && mem_wr) chk(0, "R7 both strobes", 2'b11, 2'b00);
         if (prev_strobe && !prev_done) begin
            chk(mem_rd || mem_wr, "R2/R4 strobe held", {mem_rd, mem_wr}, 1);
            chk(mem_addr == prev_addr && mem_wdata == prev_wdata, "R8 stable",
                {mem_addr, mem_wdata}, {prev_addr, prev_wdata});
         end
         if (mem_rd || mem_wr) begin
            if (!prev_strobe && seen_op) chk(idle_run >= GAP, "R7 gap", idle_run, GAP);
            idle_run = 0;
            seen_op  = 1;
         end else begin
            idle_run++;
         end
         prev_strobe = mem_rd || mem_wr;
         prev_done   = mem_done;
         prev_addr   = mem_addr;
         prev_wdata  = mem_wdata;
      end
   end

   task automatic wait_ready();
      while (!req_ready) @(negedge clk);
   endtask

   task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
      wait_ready();
      req_valid = 1; req_we = 1; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0; req_addr = ~a; req_wdata = ~d;
      chk(mem_wr && !mem_rd, "R4 write strobe", {mem_rd, mem_wr}, 2'b01);
      chk(mem_addr == a, "R4 address", mem_addr, a);
      chk(mem_wdata == d, "R4 data", mem_wdata, d);
      chk(!req_ready && !rd_valid, "R5 posted busy", {req_ready, rd_valid}, 0);
      refm[a] = d;
   endtask

   task automatic do_read(input logic [AW-1:0] a, input string tag);
      wait_ready();
      req_valid = 1; req_we = 0; req_addr = a;
      @(negedge clk);
      req_valid = 0; req_addr = ~a;
      chk(mem_rd && !mem_wr && mem_addr == a, "R2 read issue", mem_addr, a);
      while (!rd_valid) @(negedge clk);
      chk(rd_data == refm[a], tag, rd_data, refm[a]);
      @(negedge clk);
      chk(!rd_valid, "R3 single pulse", rd_valid, 0);
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready && !mem_rd && !mem_wr && !rd_valid, "R1 in reset",
          {req_ready, mem_rd, mem_wr, rd_valid}, 4'b1000);
      rst_n = 1;
      @(negedge clk);
      chk(req_ready && !mem_rd && !mem_wr && !rd_valid, "R1 after reset",
          {req_ready, mem_rd, mem_wr, rd_valid}, 4'b1000);

      // sweep: write a block, read it back (R3)
      for (int a = 0; a < 64; a++) do_write(AW'(a), DW'(a * 16'h0123 ^ 16'h5A5A));
      for (int a = 0; a < 64; a++) do_read(AW'(a), "R3 readback");

      // posted write then immediate read of same word (R9)
      for (int a = 0; a < 48; a++) begin
         do_write(AW'(a * 5), DW'(~(a * 16'h0321)));
         do_read(AW'(a * 5), "R9 read after write");
      end

      // back-to-back writes, last one wins (R9)
      do_write(8'hF0, 16'h1111);
      do_write(8'hF0, 16'h2222);
      do_write(8'hF0, 16'hBEEF);
      do_read(8'hF0, "R9 last write");

      // request held while busy is ignored (R6)
      do_write(8'h33, 16'hC0DE);
      req_valid = 1; req_we = 0; req_addr = 8'h99;
      while (!req_ready) begin
         chk(!mem_rd, "R6 no read while busy", mem_rd, 0);
         if (mem_wr) chk(mem_addr == 8'h33, "R6 address kept", mem_addr, 8'h33);
         @(negedge clk);
      end
      req_valid = 0;
      repeat (3) begin
         @(negedge clk);
         chk(!mem_rd && !mem_wr, "R6 ignored request", {mem_rd, mem_wr}, 0);
      end
      do_read(8'h33, "R6 data intact");

      repeat (4) @(negedge clk);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule